// File: doc/BRIEF.md
# Synthesizer Control Latch Sequencer

This block sits behind the serial front end of a frequency synthesizer. It takes complete 24-bit control words, each offered with a one-cycle load strobe. The two low bits of each word pick one of four destinations. Three of them are stored latches: the reference-divider latch, the feedback-divider latch and the function latch. The fourth is an initialization write, which also lands in the function latch. The upper 22 bits of the word are the payload.

From the stored state and the load history, the block drives three controls for the dividers and the charge pump:

- a divider reset/hold,
- a charge-pump three-state enable,
- a power-down output.

An initialization write emits a one-cycle internal reset pulse and arms a one-shot flag. The first feedback-divider load after that write fires the pulse once more. A pulse whose function bits select synchronous power-down, taken while chip-enable is high, latches a power-down. That power-down stays until a later function or initialization write changes the power-down bits. A counter-reset bit in the function latch holds the dividers without ever powering down. Pulling chip-enable low forces power-down at once, without a clock. The stored latches are kept through chip-enable cycles.

Top module: `synth_latch_seq`

## Requirements
- R1: A loaded word with low bits 00 stores bits [23:2] into the reference payload. Low bits 01 store them into the feedback payload, and low bits 10 store them into the function payload. The new value is visible after the loading clock edge, and every other latch keeps its value.
- R2: A word with low bits 11 (initialization) stores its bits [23:2] into the function payload, exactly as a 10 write would.
- R3: An initialization write asserts both divider_reset and cp_tristate for exactly the one cycle after its loading edge. This assumes the counter-reset bit is 0.
- R4: The first 01 load after an initialization write gives the same one-cycle pulse. Later 01 loads give none until another initialization write. After reset, with no initialization write yet, a 01 load gives no pulse.
- R5: A synchronous power-down is selected by word bit 3 = 1 (PD1) together with word bit 21 = 0 (PD2), as stored in the function latch. Such a selection latches power_down when a reset pulse fires with chip_en high. The power-down holds until a 10 or 11 write changes PD1 or PD2. A 10 write on its own never sets it.
- R6: chip_en low drives power_down and cp_tristate high at once, with no clock edge needed.
- R7: Word bit 2 (F1) of the function latch holds divider_reset and cp_tristate high for as long as it is 1, without asserting power_down. Writing F1 = 0 releases the hold.
- R8: Latch contents do not change across a chip_en low/high cycle.
- R9: After synchronous reset (rst_n low), the following are all 0: the three payloads, divider_reset, cp_tristate and power_down (with chip_en high). The one-shot flag is also cleared.
- R10: A reset pulse that fires while chip_en is low does not latch a synchronous power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_valid | input | 1 | One-cycle strobe marking a complete word |
| load_word | input | 24 | Control word; bits [1:0] select the destination |
| chip_en | input | 1 | Chip enable; low powers down asynchronously |
| divider_reset | output | 1 | Holds or resets the reference and feedback dividers |
| cp_tristate | output | 1 | Charge pump three-state enable |
| power_down | output | 1 | Power-down (synchronous latch or chip_en low) |
| ref_payload | output | 22 | Reference-divider latch contents |
| fb_payload | output | 22 | Feedback-divider latch contents |
| func_payload | output | 22 | Function latch contents |

## Verification
Words are loaded to each of the four addresses with distinct payloads, so a misrouted decode shows up as the wrong latch changing. The bench runs 01 loads in three situations: with no initialization write yet, right after one, and a second time after one. This separates correct one-shot arming from a flag that never arms or never clears. Function words with the same power-down bits and with changed power-down bits show when a latched power-down is released. Setting F1, and toggling chip_en between clock edges, separate a hold from a power-down, and separate the asynchronous path from a clocked one.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  parameter int WORD_W  = 24;
  parameter int ADDR_W  = 2;
  parameter int PAY_W   = WORD_W - ADDR_W;
  // payload bit positions (word position minus ADDR_W)
  parameter int F1_POS  = 0;
  parameter int PD1_POS = 1;
  parameter int PD2_POS = 19;

  typedef enum logic [ADDR_W-1:0] {
    DST_REF  = 2'b00,
    DST_FB   = 2'b01,
    DST_FUNC = 2'b10,
    DST_INIT = 2'b11
  } dest_e;

  function automatic dest_e word_dest(input logic [WORD_W-1:0] w);
    return dest_e'(w[ADDR_W-1:0]);
  endfunction

  function automatic logic [PAY_W-1:0] word_payload(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:ADDR_W];
  endfunction

  function automatic logic hold_sel(input logic [PAY_W-1:0] p);
    return p[F1_POS];
  endfunction

  function automatic logic sync_pd_sel(input logic [PAY_W-1:0] p);
    return p[PD1_POS] & ~p[PD2_POS];
  endfunction

  function automatic logic [1:0] pd_bits(input logic [PAY_W-1:0] p);
    return {p[PD1_POS], p[PD2_POS]};
  endfunction
endpackage

// File: rtl/latch_bank.sv
module latch_bank
  import synth_ctl_pkg::*;
#(
  parameter int PW = PAY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_valid,
  input  dest_e         dest,
  input  logic [PW-1:0] payload,
  output logic [PW-1:0] ref_q,
  output logic [PW-1:0] fb_q,
  output logic [PW-1:0] func_q
);
  logic wr_ref, wr_fb, wr_func;
  assign wr_ref  = load_valid && (dest == DST_REF);
  assign wr_fb   = load_valid && (dest == DST_FB);
  assign wr_func = load_valid && (dest == DST_FUNC || dest == DST_INIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= '0;
      fb_q   <= '0;
      func_q <= '0;
    end else begin
      if (wr_ref)  ref_q  <= payload;
      if (wr_fb)   fb_q   <= payload;
      if (wr_func) func_q <= payload;
    end
  end

  a_r2_init_to_func: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && dest == DST_INIT) |=> (func_q == $past(payload)));
  a_r8_ref_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_valid && dest == DST_REF) |=> $stable(ref_q));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import synth_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_valid,
  input  dest_e dest,
  output logic  fire,
  output logic  pulse_q,
  output logic  armed_q
);
  logic is_init, is_fb;
  assign is_init = load_valid && (dest == DST_INIT);
  assign is_fb   = load_valid && (dest == DST_FB);
  assign fire    = is_init || (is_fb && armed_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (is_init)    armed_q <= 1'b1;
      else if (is_fb) armed_q <= 1'b0;
    end
  end

  a_r3_init_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && dest == DST_INIT) |=> pulse_q);
  a_r4_fb_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && dest == DST_FB) |=> !armed_q);
endmodule

// File: rtl/power_ctl.sv
module power_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       func_wr,
  input  logic       new_sync_sel,
  input  logic [1:0] new_pd,
  input  logic [1:0] old_pd,
  input  logic       chip_en,
  output logic       pd_sync_q
);
  logic set_pd, clr_pd;
  assign set_pd = fire && new_sync_sel && chip_en;
  assign clr_pd = func_wr && (new_pd != old_pd);

  always_ff @(posedge clk) begin
    if (!rst_n)      pd_sync_q <= 1'b0;
    else if (set_pd) pd_sync_q <= 1'b1;
    else if (clr_pd) pd_sync_q <= 1'b0;
  end

  a_r5_pd_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_sync_q) |-> $past(fire && chip_en));
endmodule

// File: rtl/synth_latch_seq.sv
module synth_latch_seq
  import synth_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [WORD_W-1:0] load_word,
  input  logic              chip_en,
  output logic              divider_reset,
  output logic              cp_tristate,
  output logic              power_down,
  output logic [PAY_W-1:0]  ref_payload,
  output logic [PAY_W-1:0]  fb_payload,
  output logic [PAY_W-1:0]  func_payload
);
  dest_e            dest;
  logic [PAY_W-1:0] payload;
  logic             fire, pulse_q, armed_q, pd_sync_q, func_wr, hold;

  assign dest    = word_dest(load_word);
  assign payload = word_payload(load_word);
  assign func_wr = load_valid && (dest == DST_FUNC || dest == DST_INIT);

  latch_bank #(.PW(PAY_W)) u_latches (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .dest(dest),
    .payload(payload), .ref_q(ref_payload), .fb_q(fb_payload), .func_q(func_payload)
  );

  reset_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .dest(dest),
    .fire(fire), .pulse_q(pulse_q), .armed_q(armed_q)
  );

  // sync power-down uses the function bits in force after this load
  logic [PAY_W-1:0] func_next;
  assign func_next = func_wr ? payload : func_payload;

  power_ctl u_pwr (
    .clk(clk), .rst_n(rst_n), .fire(fire), .func_wr(func_wr),
    .new_sync_sel(sync_pd_sel(func_next)), .new_pd(pd_bits(payload)),
    .old_pd(pd_bits(func_payload)), .chip_en(chip_en), .pd_sync_q(pd_sync_q)
  );

  assign hold          = hold_sel(func_payload);
  assign divider_reset = pulse_q | hold;
  assign power_down    = pd_sync_q | ~chip_en;
  assign cp_tristate   = divider_reset | power_down;

  a_r7_hold_no_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !pulse_q && chip_en && !$past(fire)) |-> (power_down == $past(pd_sync_q)));
endmodule

// File: tb/test_synth_latch_seq.sv
`timescale 1ns/1ps
module test_synth_latch_seq;
  logic        clk = 0, rst_n = 0, load_valid = 0, chip_en = 1;
  logic [23:0] load_word = '0;
  logic        divider_reset, cp_tristate, power_down;
  logic [21:0] ref_payload, fb_payload, func_payload;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  synth_latch_seq i_synth_latch_seq (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_word(load_word),
    .chip_en(chip_en), .divider_reset(divider_reset), .cp_tristate(cp_tristate),
    .power_down(power_down), .ref_payload(ref_payload), .fb_payload(fb_payload),
    .func_payload(func_payload)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // function payload: F1 at payload bit 0, PD1 at bit 1, PD2 at bit 19
  function automatic logic [21:0] fpay(input logic f1, input logic pd1, input logic pd2, input logic [21:0] extra);
    logic [21:0] p;
    p = extra & ~22'h080003;
    p[0] = f1; p[1] = pd1; p[19] = pd2;
    return p;
  endfunction

  task automatic do_load(input logic [1:0] addr, input logic [21:0] pay);
    @(negedge clk);
    load_valid = 1; load_word = {pay, addr};
    @(negedge clk);
    load_valid = 0; load_word = '0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9", "divider_reset", divider_reset, 0);
    check("R9", "cp_tristate", cp_tristate, 0);
    check("R9", "power_down", power_down, 0);
    check("R9", "payloads", {ref_payload | fb_payload | func_payload}, 0);
  endtask

  task automatic t_decode;
    do_load(2'b00, 22'h12345);
    check("R1", "ref after 00", ref_payload, 22'h12345);
    check("R1", "fb untouched", fb_payload, 0);
    do_load(2'b01, 22'h2abcd);
    check("R1", "fb after 01", fb_payload, 22'h2abcd);
    check("R4", "no pulse unarmed", divider_reset, 0);
    do_load(2'b10, fpay(0, 0, 0, 22'h15550));
    check("R1", "func after 10", func_payload, fpay(0, 0, 0, 22'h15550));
    check("R1", "ref kept", ref_payload, 22'h12345);
  endtask

  task automatic t_init;
    do_load(2'b11, fpay(0, 0, 0, 22'h0a0f0));
    check("R2", "func from init", func_payload, fpay(0, 0, 0, 22'h0a0f0));
    check("R3", "pulse div", divider_reset, 1);
    check("R3", "pulse cp", cp_tristate, 1);
    check("R3", "no pd", power_down, 0);
    @(negedge clk);
    check("R3", "pulse ends", divider_reset, 0);
    do_load(2'b01, 22'h00777);
    check("R4", "first fb pulses", divider_reset, 1);
    @(negedge clk);
    check("R4", "fb pulse ends", divider_reset, 0);
    do_load(2'b01, 22'h00778);
    check("R4", "second fb no pulse", divider_reset, 0);
    check("R4", "fb stored", fb_payload, 22'h00778);
  endtask

  task automatic t_hold;
    do_load(2'b10, fpay(1, 0, 0, 0));
    repeat (3) @(negedge clk);
    check("R7", "hold div", divider_reset, 1);
    check("R7", "hold cp", cp_tristate, 1);
    check("R7", "hold no pd", power_down, 0);
    do_load(2'b10, fpay(0, 0, 0, 0));
    check("R7", "release", divider_reset, 0);
  endtask

  task automatic t_syncpd;
    do_load(2'b10, fpay(0, 1, 0, 0));
    check("R5", "func write alone no pd", power_down, 0);
    do_load(2'b11, fpay(0, 1, 0, 0));
    check("R5", "init sets pd", power_down, 1);
    repeat (3) @(negedge clk);
    check("R5", "pd latched", power_down, 1);
    do_load(2'b01, 22'h00100);
    do_load(2'b10, fpay(0, 1, 0, 22'h00400));
    check("R5", "same bits keep pd", power_down, 1);
    do_load(2'b10, fpay(0, 0, 0, 0));
    check("R5", "changed bits clear pd", power_down, 0);
  endtask

  task automatic t_ce;
    @(negedge clk);
    #2 chip_en = 0;
    #1;
    check("R6", "async pd", power_down, 1);
    check("R6", "async cp", cp_tristate, 1);
    do_load(2'b11, fpay(0, 1, 0, 0));
    @(negedge clk);
    chip_en = 1;
    #1;
    check("R10", "no pd from pulse at ce low", power_down, 0);
    check("R8", "ref kept over ce", ref_payload, 22'h12345);
    check("R8", "fb kept over ce", fb_payload, 22'h00100);
  endtask

  initial begin
    t_reset();
    t_decode();
    t_init();
    t_hold();
    t_syncpd();
    t_ce();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule